// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Aggregator

This block gathers single-cycle event pulses from two sources into sticky status bits. One source is the error section of a serial UART receiver. The other is a smart card interface controller, which reports faults such as timing-window violations. The block keeps two status words and drives one interrupt line.

The line-status word holds the sticky UART event bits and two live transmitter indications: shift register empty and holding register empty. The controller status word holds a full copy of the line-status word in its low bits and the controller's own sticky event bits above it. Reading a status word clears the sticky bits it shows. Because the UART bits are mirrored, a read of the controller word also clears the UART sticky bits. The two transmitter-empty bits always reflect their source levels, and no read affects them.

Each bit of the line-status word has its own enable. Each controller event bit has its own enable. A master enable gates the final interrupt, which comes from a register.

Top module: `irqStatusAgg`

## Requirements
- R1: While reset (`rstN` low) is asserted, every sticky status bit and `irq` read 0.
- R2: A pulse on `uartEvt[i]` at a clock edge sets `lineStat[i]` from that edge on. The bit stays set until a read clears it.
- R3: A pulse on `ctlEvt[j]` at a clock edge sets `ctlStat[UEW+2+j]` from that edge on. The bit stays set until a controller-word read clears it.
- R4: `ctlStat[UEW+1:0]` always equals `lineStat`.
- R5: `rdLineStat` high at an edge clears the UART sticky bits `lineStat[UEW-1:0]` and leaves the controller sticky bits unchanged.
- R6: `rdCtlStat` high at an edge clears both the controller sticky bits and the UART sticky bits.
- R7: `lineStat[UEW]` equals `txShiftEmpty` and `lineStat[UEW+1]` equals `txHoldEmpty` in the same cycle. Neither read strobe changes them.
- R8: When an event pulse and a clearing read hit the same bit at the same edge, the bit ends up set.
- R9: At each edge, `irq` loads the value that is high only if `masterIntEn` is high and at least one enabled bit is set before that edge. Enabled bits are any `lineStat[k]` with `lineIntEn[k]` high, and any controller sticky bit j with `ctlIntEn[j]` high.
- R10: When `masterIntEn` is low at an edge, `irq` is low after that edge, whatever status is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uartEvt | input | UEW | UART event pulses |
| ctlEvt | input | CEW | Controller event pulses |
| txShiftEmpty | input | 1 | Live level: transmit shift register empty |
| txHoldEmpty | input | 1 | Live level: transmit holding register empty |
| lineIntEn | input | UEW+2 | Per-bit interrupt enables for the line-status word |
| ctlIntEn | input | CEW | Per-bit interrupt enables for the controller event bits |
| masterIntEn | input | 1 | Master interrupt enable |
| rdLineStat | input | 1 | Read strobe for the line-status word |
| rdCtlStat | input | 1 | Read strobe for the controller status word |
| lineStat | output | UEW+2 | Line-status word |
| ctlStat | output | UEW+2+CEW | Controller status word (mirror in low bits) |
| irq | output | 1 | Interrupt line |

## Verification
The timing of each result is fixed:
- A sticky bit shows the effect of an event pulse or a read strobe immediately after the edge that samples it.
- The live transmitter-empty bits follow their inputs within the same cycle.
- The interrupt is one register further downstream. It reflects status and enables as they stood before an edge, so it rises one edge after the sticky bit it depends on.

The bench drives every input just after a falling edge. For the coming rising edge it computes the full expected pair of status words and the expected interrupt, and pushes them into a queue. A monitor pops one entry two nanoseconds after that rising edge, so each comparison lands exactly one edge after its stimulus.

// File: rtl/irqStatusPkg.sv
package irqStatusPkg;

  // Clear strobes issued by the control section to the datapath.
  typedef struct packed {
    logic clrUart;  // clear UART sticky bits
    logic clrCtl;   // clear controller sticky bits
  } clrStrobe_t;

endpackage

// File: rtl/irqStickyCell.sv
module irqStickyCell (
  input  logic clk,
  input  logic rstN,
  input  logic setP,
  input  logic clrP,
  output logic q
);

  // set has priority over clear so a coincident event is never lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= 1'b0;
    else if (setP)  q <= 1'b1;
    else if (clrP)  q <= 1'b0;
  end

endmodule

// File: rtl/irqClrCtrl.sv
module irqClrCtrl
  import irqStatusPkg::*;
(
  input  logic       rdLineStat,
  input  logic       rdCtlStat,
  output clrStrobe_t clr
);

  // The UART bits are visible in both words, so either read clears them.
  always_comb begin
    clr.clrUart = rdLineStat | rdCtlStat;
    clr.clrCtl  = rdCtlStat;
  end

endmodule

// File: rtl/irqStatusPath.sv
module irqStatusPath
  import irqStatusPkg::*;
#(
  parameter int UEW = 4,
  parameter int CEW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [UEW-1:0]     uartEvt,
  input  logic [CEW-1:0]     ctlEvt,
  input  logic               txShiftEmpty,
  input  logic               txHoldEmpty,
  input  logic [UEW+1:0]     lineIntEn,
  input  logic [CEW-1:0]     ctlIntEn,
  input  logic               masterIntEn,
  input  clrStrobe_t         clr,
  output logic [UEW+1:0]     lineStat,
  output logic [UEW+2+CEW-1:0] ctlStat,
  output logic               irq
);

  localparam int LW = UEW + 2;
  localparam int CW = LW + CEW;

  logic [UEW-1:0] uartSticky;
  logic [CEW-1:0] ctlSticky;
  logic           linePend;
  logic           ctlPend;

  genvar gi;
  generate
    for (gi = 0; gi < UEW; gi++) begin : gUart
      irqStickyCell uCell (
        .clk  (clk),
        .rstN (rstN),
        .setP (uartEvt[gi]),
        .clrP (clr.clrUart),
        .q    (uartSticky[gi])
      );
    end
    for (gi = 0; gi < CEW; gi++) begin : gCtl
      irqStickyCell uCell (
        .clk  (clk),
        .rstN (rstN),
        .setP (ctlEvt[gi]),
        .clrP (clr.clrCtl),
        .q    (ctlSticky[gi])
      );
    end
  endgenerate

  // live transmitter levels sit above the sticky UART bits
  always_comb begin
    lineStat = {txHoldEmpty, txShiftEmpty, uartSticky};
    ctlStat  = {ctlSticky, lineStat};
  end

  always_comb begin
    linePend = |(lineStat & lineIntEn);
    ctlPend  = |(ctlStat[CW-1:LW] & ctlIntEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= masterIntEn & (linePend | ctlPend);
  end

endmodule

// File: rtl/irqStatusAgg.sv
module irqStatusAgg
  import irqStatusPkg::*;
#(
  parameter int UEW = 4,
  parameter int CEW = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [UEW-1:0]       uartEvt,
  input  logic [CEW-1:0]       ctlEvt,
  input  logic                 txShiftEmpty,
  input  logic                 txHoldEmpty,
  input  logic [UEW+1:0]       lineIntEn,
  input  logic [CEW-1:0]       ctlIntEn,
  input  logic                 masterIntEn,
  input  logic                 rdLineStat,
  input  logic                 rdCtlStat,
  output logic [UEW+1:0]       lineStat,
  output logic [UEW+2+CEW-1:0] ctlStat,
  output logic                 irq
);

  clrStrobe_t clrS;

  irqClrCtrl uCtrl (
    .rdLineStat (rdLineStat),
    .rdCtlStat  (rdCtlStat),
    .clr        (clrS)
  );

  irqStatusPath #(.UEW(UEW), .CEW(CEW)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .uartEvt      (uartEvt),
    .ctlEvt       (ctlEvt),
    .txShiftEmpty (txShiftEmpty),
    .txHoldEmpty  (txHoldEmpty),
    .lineIntEn    (lineIntEn),
    .ctlIntEn     (ctlIntEn),
    .masterIntEn  (masterIntEn),
    .clr          (clrS),
    .lineStat     (lineStat),
    .ctlStat      (ctlStat),
    .irq          (irq)
  );

endmodule

// File: rtl/irqStatusAggChk.sv
module irqStatusAggChk #(
  parameter int UEW = 4,
  parameter int CEW = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [UEW-1:0]       uartEvt,
  input logic [CEW-1:0]       ctlEvt,
  input logic [UEW+1:0]       lineIntEn,
  input logic [CEW-1:0]       ctlIntEn,
  input logic                 masterIntEn,
  input logic                 rdLineStat,
  input logic                 rdCtlStat,
  input logic [UEW+1:0]       lineStat,
  input logic [UEW+2+CEW-1:0] ctlStat,
  input logic                 irq
);

  localparam int LW = UEW + 2;
  localparam int CW = LW + CEW;

  assert_uart_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (uartEvt != '0) |=> ((lineStat[UEW-1:0] & $past(uartEvt)) == $past(uartEvt)));

  assert_uart_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdLineStat && !rdCtlStat) |=> (($past(lineStat[UEW-1:0]) & ~lineStat[UEW-1:0]) == '0));

  assert_ctl_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEvt != '0) |=> ((ctlStat[CW-1:LW] & $past(ctlEvt)) == $past(ctlEvt)));

  assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdCtlStat |=> (($past(ctlStat[CW-1:LW]) & ~ctlStat[CW-1:LW]) == '0));

  assert_line_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdLineStat |=> ((lineStat[UEW-1:0] & ~$past(uartEvt)) == '0));

  assert_ctl_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdCtlStat |=> (((ctlStat[CW-1:LW] & ~$past(ctlEvt)) == '0) &&
                   ((ctlStat[UEW-1:0] & ~$past(uartEvt)) == '0)));

  assert_irq_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(masterIntEn && (((lineStat & lineIntEn) != '0) ||
                                           ((ctlStat[CW-1:LW] & ctlIntEn) != '0)))));

  assert_master_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !masterIntEn |=> !irq);

endmodule

bind irqStatusAgg irqStatusAggChk #(.UEW(UEW), .CEW(CEW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .uartEvt     (uartEvt),
  .ctlEvt      (ctlEvt),
  .lineIntEn   (lineIntEn),
  .ctlIntEn    (ctlIntEn),
  .masterIntEn (masterIntEn),
  .rdLineStat  (rdLineStat),
  .rdCtlStat   (rdCtlStat),
  .lineStat    (lineStat),
  .ctlStat     (ctlStat),
  .irq         (irq)
);

// File: tb/sim_irqStatusAgg.sv
module sim_irqStatusAgg;

  localparam int UEW = 4;
  localparam int CEW = 5;
  localparam int LW  = UEW + 2;
  localparam int CW  = LW + CEW;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [UEW-1:0] uartEvt = '0;
  logic [CEW-1:0] ctlEvt = '0;
  logic           txShiftEmpty = 1'b0;
  logic           txHoldEmpty = 1'b0;
  logic [LW-1:0]  lineIntEn = '0;
  logic [CEW-1:0] ctlIntEn = '0;
  logic           masterIntEn = 1'b0;
  logic           rdLineStat = 1'b0;
  logic           rdCtlStat = 1'b0;
  logic [LW-1:0]  lineStat;
  logic [CW-1:0]  ctlStat;
  logic           irq;

  irqStatusAgg #(.UEW(UEW), .CEW(CEW)) u0 (
    .clk(clk), .rstN(rstN), .uartEvt(uartEvt), .ctlEvt(ctlEvt),
    .txShiftEmpty(txShiftEmpty), .txHoldEmpty(txHoldEmpty),
    .lineIntEn(lineIntEn), .ctlIntEn(ctlIntEn), .masterIntEn(masterIntEn),
    .rdLineStat(rdLineStat), .rdCtlStat(rdCtlStat),
    .lineStat(lineStat), .ctlStat(ctlStat), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [LW-1:0] line;
    logic [CW-1:0] ctl;
    logic          irqV;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  logic [UEW-1:0] mUart = '0;
  logic [CEW-1:0] mCtl = '0;
  logic [LW-1:0]  enLine = '0;
  logic [CEW-1:0] enCtl = '0;
  logic           enMaster = 1'b0;

  task automatic drive(input logic [UEW-1:0] ue, input logic [CEW-1:0] ce,
                       input logic rl, input logic rc,
                       input logic ts, input logic th, input string tag);
    expItem_t it;
    logic pend;
    @(negedge clk);
    uartEvt = ue; ctlEvt = ce; rdLineStat = rl; rdCtlStat = rc;
    txShiftEmpty = ts; txHoldEmpty = th;
    lineIntEn = enLine; ctlIntEn = enCtl; masterIntEn = enMaster;
    pend = ((({th, ts, mUart}) & enLine) != '0) || ((mCtl & enCtl) != '0);
    it.irqV = enMaster & pend;
    mUart = ue | (mUart & ~{UEW{rl | rc}});
    mCtl  = ce | (mCtl & ~{CEW{rc}});
    it.line = {th, ts, mUart};
    it.ctl  = {mCtl, th, ts, mUart};
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // monitor: one expected item per rising edge, sampled off the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (lineStat !== e.line || ctlStat !== e.ctl || irq !== e.irqV) begin
          errors++;
          $display("FAIL %s line act %h exp %h ctl act %h exp %h irq act %b exp %b",
                   e.tag, lineStat, e.line, ctlStat, e.ctl, irq, e.irqV);
        end
      end
    end
  end

  initial begin
    #12;
    checks++;
    if (lineStat !== '0 || ctlStat !== '0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset line %h ctl %h irq %b exp all 0", lineStat, ctlStat, irq);
    end
    @(negedge clk);
    rstN = 1'b1;

    drive('0, '0, 0, 0, 0, 0, "R1");
    drive(4'b0001, '0, 0, 0, 0, 0, "R2");
    drive('0, '0, 0, 0, 0, 0, "R2");
    drive('0, 5'b00100, 0, 0, 0, 0, "R3");
    drive('0, '0, 0, 0, 0, 0, "R4");
    drive(4'b1000, '0, 0, 0, 0, 0, "R4");
    drive('0, '0, 1, 0, 0, 0, "R5");
    drive('0, '0, 0, 0, 0, 0, "R5");
    drive(4'b1010, 5'b00011, 0, 0, 0, 0, "R2");
    drive('0, '0, 0, 1, 0, 0, "R6");
    drive('0, '0, 0, 0, 0, 0, "R6");
    drive('0, '0, 0, 0, 1, 0, "R7");
    drive('0, '0, 1, 1, 1, 1, "R7");
    drive('0, '0, 0, 0, 0, 1, "R7");
    drive(4'b0100, '0, 1, 0, 0, 0, "R8");
    drive('0, 5'b10000, 0, 1, 0, 0, "R8");
    drive(4'b0001, '0, 0, 1, 0, 0, "R8");
    drive('0, '0, 0, 0, 0, 0, "R8");

    // interrupt generation
    enLine = '1; enCtl = '1; enMaster = 1'b1;
    drive('0, '0, 0, 0, 0, 0, "R9");
    drive('0, '0, 0, 0, 0, 0, "R9");
    drive('0, '0, 0, 1, 0, 0, "R9");
    drive('0, '0, 0, 0, 0, 0, "R9");
    enLine = '0; enCtl = 5'b00010;
    drive('0, 5'b00001, 0, 0, 0, 0, "R9");
    drive('0, '0, 0, 0, 0, 0, "R9");
    drive('0, 5'b00010, 0, 0, 0, 0, "R9");
    drive('0, '0, 0, 0, 0, 0, "R9");
    enLine = 6'b010000; enCtl = '0;
    drive('0, '0, 0, 1, 1, 0, "R9");
    drive('0, '0, 0, 0, 1, 0, "R9");
    drive('0, '0, 0, 0, 0, 0, "R9");
    enLine = '1; enCtl = '1; enMaster = 1'b0;
    drive(4'b1111, 5'b11111, 0, 0, 1, 1, "R10");
    drive('0, '0, 0, 0, 1, 1, "R10");
    enMaster = 1'b1;
    drive('0, '0, 0, 0, 1, 1, "R10");
    drive('0, '0, 0, 0, 0, 0, "R9");
    enMaster = 1'b0;
    drive('0, '0, 0, 0, 0, 0, "R10");
    drive('0, '0, 0, 0, 0, 0, "R10");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule